// File: doc/BRIEF.md
# Receive destination address filter

This block sits beside a receive MAC and gives an accept or drop verdict for each incoming Ethernet frame, judged only by the frame's 48-bit destination address and three class flags (multicast, broadcast, control). The receive front end pulses a start strobe together with the address and flags; exactly two clock cycles later the filter raises a one-cycle valid pulse with the verdict beside it. Framing, CRC checking and data movement stay with the front end.

Software programs a small word-addressed register file: eight exact-match address slots and one filter control word. Slot 0 always takes part in matching. Slots 1 to 7 take part only once their enable bit is set. Three control bits change the decision: accept everything, accept every multicast frame, and pass control frames. Broadcast frames are always accepted. Any other frame that no active slot matches is dropped.

Top module: `rxf_dst_filter`

## Requirements
- R1: After reset every register reads back as zero and `flt_valid` and `flt_accept` are low.
- R2: A `rx_sof` pulse sampled at one rising edge makes `flt_valid` high for exactly the cycle that follows the second rising edge after it, and `flt_accept` is low whenever `flt_valid` is low.
- R3: Slot 0 (low word at 0x50, high word at 0x54) always takes part in matching, whatever its enable bit holds. After reset it holds address zero, so a non-control frame with destination zero is accepted.
- R4: Slot n for n from 1 to 7 (low word at 0x50+8n, high word at 0x54+8n) matches only while bit 31 of its high word is 1.
- R5: Writing zero to the high word of slot 1 to 7 clears that slot, so it no longer matches any destination.
- R6: Bit 0 of the control word at 0x38 accepts every frame, control frames included, and overrides every other rule.
- R7: Bit 16 of the control word accepts every non-control frame flagged multicast, whatever the slots hold.
- R8: While bit 0 is clear, a frame flagged as control is accepted only when bit 13 of the control word is 1, and its address plays no part.
- R9: A non-control frame flagged broadcast is always accepted.
- R10: A non-control frame that is not broadcast, is not covered by bit 16 and matches no active slot is dropped.
- R11: Destination byte k is `rx_dst[8k+7:8k]`. The low word of a slot holds bytes 0 to 3 with byte 0 in bits 7:0, and bits 15:0 of the high word hold byte 4 (bits 7:0) and byte 5 (bits 15:8).
- R12: Only the defined bits are stored: a high word reads back bits 31 and 15:0, the control word reads back bits 16, 13 and 0, the low word all 32 bits, and every other bit reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 8 | Register write byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 8 | Register read byte address |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_raddr` |
| rx_sof | input | 1 | Start-of-frame strobe, qualifies the fields below |
| rx_dst | input | 48 | Destination address of the frame |
| rx_is_mcast | input | 1 | Frame is multicast |
| rx_is_bcast | input | 1 | Frame is broadcast |
| rx_is_ctrl | input | 1 | Frame is a control frame |
| flt_valid | output | 1 | Verdict strobe, two cycles after `rx_sof` |
| flt_accept | output | 1 | Verdict: 1 accept, 0 drop |

## Verification
The assertions watch the verdict timing on every cycle, that a verdict is never asserted without its strobe, and the three override paths that depend only on ports and control bits: accept-all, broadcast and multicast pass-through, and control-frame blocking. Exact-match behaviour (slot 0 always active, per-slot enables, clearing a slot, byte order within the address) and the register readback masks depend on stored slot contents, so only the bench's directed cases and its randomized frames checked against a reference model show them.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int unsigned MAC_W          = 48;
  localparam int unsigned CTRL_PROM_BIT  = 0;
  localparam int unsigned CTRL_CPASS_BIT = 13;
  localparam int unsigned CTRL_MALL_BIT  = 16;
  localparam int unsigned SLOT_EN_BIT    = 31;

  typedef struct packed {
    logic prom;   // accept every frame
    logic mall;   // accept every multicast frame
    logic cpass;  // pass control frames
  } rxf_ctrl_t;

endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned AW        = 8,
  parameter int unsigned CTRL_OFS  = 'h38,
  parameter int unsigned SLOT_BASE = 'h50
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [AW-1:0]                      waddr,
  input  logic [31:0]                        wdata,
  input  logic [AW-1:0]                      raddr,
  output logic [31:0]                        rdata,
  output logic [NUM_SLOTS-1:0][MAC_W-1:0]    slot_addr,
  output logic [NUM_SLOTS-1:0]               slot_act,
  output rxf_ctrl_t                          ctrl
);

  localparam int unsigned IDX_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int unsigned SPAN   = NUM_SLOTS * 8;
  localparam logic [AW-1:0] CTRL_A = AW'(CTRL_OFS);
  localparam logic [AW-1:0] BASE_A = AW'(SLOT_BASE);
  localparam logic [AW-1:0] SPAN_A = AW'(SPAN);

  logic [NUM_SLOTS-1:0][31:0] lo_q, lo_d;
  logic [NUM_SLOTS-1:0][15:0] hi_q, hi_d;
  logic [NUM_SLOTS-1:0]       en_q, en_d;
  rxf_ctrl_t                  ctrl_q, ctrl_d;

  logic [AW-1:0]    w_off, r_off;
  logic             w_slot, r_slot;
  logic [IDX_W-1:0] w_idx, r_idx;
  logic             wr_ctrl, wr_hit;
  logic             unused_off;

  // write decode and next state
  always_comb begin
    w_off   = waddr - BASE_A;
    w_slot  = (waddr >= BASE_A) && (w_off < SPAN_A) && (waddr[1:0] == 2'b00);
    w_idx   = w_off[IDX_W+2:3];
    wr_ctrl = we && (waddr == CTRL_A);
    wr_hit  = wr_ctrl || (we && w_slot);
    lo_d    = lo_q;
    hi_d    = hi_q;
    en_d    = en_q;
    ctrl_d  = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.prom  = wdata[CTRL_PROM_BIT];
      ctrl_d.mall  = wdata[CTRL_MALL_BIT];
      ctrl_d.cpass = wdata[CTRL_CPASS_BIT];
    end else if (we && w_slot) begin
      if (w_off[2]) begin
        hi_d[w_idx] = wdata[15:0];
        en_d[w_idx] = wdata[SLOT_EN_BIT];
      end else begin
        lo_d[w_idx] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      en_q   <= '0;
      ctrl_q <= '0;
    end else if (wr_hit) begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      en_q   <= en_d;
      ctrl_q <= ctrl_d;
    end
  end

  // read decode
  always_comb begin
    r_off  = raddr - BASE_A;
    r_slot = (raddr >= BASE_A) && (r_off < SPAN_A) && (raddr[1:0] == 2'b00);
    r_idx  = r_off[IDX_W+2:3];
    rdata  = '0;
    if (raddr == CTRL_A) begin
      rdata[CTRL_PROM_BIT]  = ctrl_q.prom;
      rdata[CTRL_MALL_BIT]  = ctrl_q.mall;
      rdata[CTRL_CPASS_BIT] = ctrl_q.cpass;
    end else if (r_slot) begin
      if (r_off[2]) begin
        rdata[15:0]        = hi_q[r_idx];
        rdata[SLOT_EN_BIT] = en_q[r_idx];
      end else begin
        rdata = lo_q[r_idx];
      end
    end
  end

  assign unused_off = ^{w_off, r_off};
  assign ctrl       = ctrl_q;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_addr[g] = {hi_q[g], lo_q[g]};
    if (g == 0) begin : g_fixed
      assign slot_act[g] = 1'b1;
    end else begin : g_prog
      assign slot_act[g] = en_q[g];
    end
  end

endmodule

// File: rtl/rxf_slot_cmp.sv
module rxf_slot_cmp
  import rxf_pkg::*;
(
  input  logic [MAC_W-1:0] slot_addr,
  input  logic             slot_act,
  input  logic [MAC_W-1:0] dst,
  output logic             hit
);

  assign hit = slot_act && (slot_addr == dst);

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic [NUM_SLOTS-1:0] hits,
  input  logic                 is_bcast,
  input  logic                 is_mcast,
  input  logic                 is_ctrl,
  input  rxf_ctrl_t            ctrl,
  output logic                 accept
);

  always_comb begin
    if (ctrl.prom) begin
      accept = 1'b1;
    end else if (is_ctrl) begin
      accept = ctrl.cpass;
    end else begin
      accept = is_bcast || (is_mcast && ctrl.mall) || (|hits);
    end
  end

endmodule

// File: rtl/rxf_dst_filter.sv
module rxf_dst_filter
  import rxf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned AW        = 8,
  parameter int unsigned CTRL_OFS  = 'h38,
  parameter int unsigned SLOT_BASE = 'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_waddr,
  input  logic [31:0]       cfg_wdata,
  input  logic [AW-1:0]     cfg_raddr,
  output logic [31:0]       cfg_rdata,
  input  logic              rx_sof,
  input  logic [MAC_W-1:0]  rx_dst,
  input  logic              rx_is_mcast,
  input  logic              rx_is_bcast,
  input  logic              rx_is_ctrl,
  output logic              flt_valid,
  output logic              flt_accept
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_addr;
  logic [NUM_SLOTS-1:0]            slot_act;
  rxf_ctrl_t                       ctrl;
  logic                            cfg_prom, cfg_mall, cfg_cpass;

  rxf_regs #(
    .NUM_SLOTS (NUM_SLOTS),
    .AW        (AW),
    .CTRL_OFS  (CTRL_OFS),
    .SLOT_BASE (SLOT_BASE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we        (cfg_we),
    .waddr     (cfg_waddr),
    .wdata     (cfg_wdata),
    .raddr     (cfg_raddr),
    .rdata     (cfg_rdata),
    .slot_addr (slot_addr),
    .slot_act  (slot_act),
    .ctrl      (ctrl)
  );

  assign cfg_prom  = ctrl.prom;
  assign cfg_mall  = ctrl.mall;
  assign cfg_cpass = ctrl.cpass;

  // stage 0: compare every slot against the incoming address
  logic [NUM_SLOTS-1:0] hit_c;
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    rxf_slot_cmp u_cmp (
      .slot_addr (slot_addr[g]),
      .slot_act  (slot_act[g]),
      .dst       (rx_dst),
      .hit       (hit_c[g])
    );
  end

  // stage 1 registers
  logic                 s1_valid_q, s1_valid_d;
  logic [NUM_SLOTS-1:0] s1_hit_q, s1_hit_d;
  logic                 s1_bc_q, s1_bc_d, s1_mc_q, s1_mc_d, s1_ctl_q, s1_ctl_d;
  rxf_ctrl_t            s1_cfg_q, s1_cfg_d;

  always_comb begin
    s1_valid_d = rx_sof;
    s1_hit_d   = hit_c;
    s1_bc_d    = rx_is_bcast;
    s1_mc_d    = rx_is_mcast;
    s1_ctl_d   = rx_is_ctrl;
    s1_cfg_d   = ctrl;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_hit_q <= '0;
      s1_bc_q  <= 1'b0;
      s1_mc_q  <= 1'b0;
      s1_ctl_q <= 1'b0;
      s1_cfg_q <= '0;
    end else if (rx_sof) begin
      s1_hit_q <= s1_hit_d;
      s1_bc_q  <= s1_bc_d;
      s1_mc_q  <= s1_mc_d;
      s1_ctl_q <= s1_ctl_d;
      s1_cfg_q <= s1_cfg_d;
    end
  end

  // stage 2: decision and output registers
  logic acc_c;
  rxf_decide #(.NUM_SLOTS(NUM_SLOTS)) u_decide (
    .hits     (s1_hit_q),
    .is_bcast (s1_bc_q),
    .is_mcast (s1_mc_q),
    .is_ctrl  (s1_ctl_q),
    .ctrl     (s1_cfg_q),
    .accept   (acc_c)
  );

  logic out_valid_d, out_accept_d, out_valid_q, out_accept_q;
  always_comb begin
    out_valid_d  = s1_valid_q;
    out_accept_d = s1_valid_q && acc_c;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid_q  <= 1'b0;
      out_accept_q <= 1'b0;
    end else begin
      out_valid_q  <= out_valid_d;
      out_accept_q <= out_accept_d;
    end
  end

  assign flt_valid  = out_valid_q;
  assign flt_accept = out_accept_q;

endmodule

// File: rtl/rxf_dst_filter_chk.sv
module rxf_dst_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_sof,
  input logic rx_is_mcast,
  input logic rx_is_bcast,
  input logic rx_is_ctrl,
  input logic flt_valid,
  input logic flt_accept,
  input logic cfg_prom,
  input logic cfg_mall,
  input logic cfg_cpass
);

  // R2: strobe two cycles after start
  p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sof |=> ##1 flt_valid);

  // R2: no strobe without a start two cycles earlier
  p_valid_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> $past(rx_sof, 2));

  // R2: verdict only together with strobe
  p_accept_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_valid |-> !flt_accept);

  // R6
  p_promisc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sof && cfg_prom) |=> ##1 flt_accept);

  // R7
  p_allmulti_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sof && rx_is_mcast && !rx_is_ctrl && cfg_mall) |=> ##1 flt_accept);

  // R8
  p_ctrl_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sof && rx_is_ctrl && !cfg_prom && !cfg_cpass) |=> ##1 !flt_accept);

  // R9
  p_bcast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sof && rx_is_bcast && !rx_is_ctrl) |=> ##1 flt_accept);

endmodule

bind rxf_dst_filter rxf_dst_filter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_sof      (rx_sof),
  .rx_is_mcast (rx_is_mcast),
  .rx_is_bcast (rx_is_bcast),
  .rx_is_ctrl  (rx_is_ctrl),
  .flt_valid   (flt_valid),
  .flt_accept  (flt_accept),
  .cfg_prom    (cfg_prom),
  .cfg_mall    (cfg_mall),
  .cfg_cpass   (cfg_cpass)
);

// File: tb/rxf_dst_filter_bench.sv
module rxf_dst_filter_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_waddr;
  logic [31:0] cfg_wdata;
  logic [7:0]  cfg_raddr;
  logic [31:0] cfg_rdata;
  logic        rx_sof;
  logic [47:0] rx_dst;
  logic        rx_is_mcast, rx_is_bcast, rx_is_ctrl;
  logic        flt_valid, flt_accept;

  int n_checks = 0;
  int n_bad    = 0;
  bit done     = 0;

  // shadow of the programmed state, kept from the requirements
  logic [31:0] m_lo [8];
  logic [15:0] m_hi [8];
  logic        m_en [8];
  logic        m_prom, m_mall, m_cpass;

  rxf_dst_filter u_rxf_dst_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_waddr   (cfg_waddr),
    .cfg_wdata   (cfg_wdata),
    .cfg_raddr   (cfg_raddr),
    .cfg_rdata   (cfg_rdata),
    .rx_sof      (rx_sof),
    .rx_dst      (rx_dst),
    .rx_is_mcast (rx_is_mcast),
    .rx_is_bcast (rx_is_bcast),
    .rx_is_ctrl  (rx_is_ctrl),
    .flt_valid   (flt_valid),
    .flt_accept  (flt_accept)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic model_accept(logic [47:0] d, logic mc, logic bc, logic ct);
    logic hit = 1'b0;
    for (int i = 0; i < 8; i++)
      if ((i == 0 || m_en[i]) && {m_hi[i], m_lo[i]} == d) hit = 1'b1;
    if (m_prom) return 1'b1;
    if (ct) return m_cpass;
    return bc | (mc & m_mall) | hit;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    int idx;
    if (a == 8'h38) return (32'(m_mall) << 16) | (32'(m_cpass) << 13) | 32'(m_prom);
    if (a >= 8'h50 && a < 8'h90 && a[1:0] == 2'b00) begin
      idx = int'(a - 8'h50) / 8;
      if (a[2]) return {m_en[idx], 15'd0, m_hi[idx]};
      return m_lo[idx];
    end
    return 32'd0;
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    int idx;
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 8'h38) begin
      m_prom = d[0]; m_cpass = d[13]; m_mall = d[16];
    end else if (a >= 8'h50 && a < 8'h90 && a[1:0] == 2'b00) begin
      idx = int'(a - 8'h50) / 8;
      if (a[2]) begin m_hi[idx] = d[15:0]; m_en[idx] = d[31]; end
      else m_lo[idx] = d;
    end
  endtask

  task automatic read_check(input logic [7:0] a, input string req);
    logic [31:0] e;
    e = model_read(a);
    cfg_raddr = a;
    #1;
    check(cfg_rdata == e, req, 48'(cfg_rdata), 48'(e));
  endtask

  task automatic send(input logic [47:0] d, input logic mc, input logic bc, input logic ct,
                      input string req);
    logic e;
    e = model_accept(d, mc, bc, ct);
    @(negedge clk);
    rx_sof = 1'b1; rx_dst = d; rx_is_mcast = mc; rx_is_bcast = bc; rx_is_ctrl = ct;
    @(negedge clk);
    rx_sof = 1'b0;
    check(flt_valid == 1'b0, "R2 early strobe", 48'(flt_valid), 48'd0);
    @(negedge clk);
    check(flt_valid == 1'b1, "R2 strobe", 48'(flt_valid), 48'd1);
    check(flt_accept == e, req, 48'(flt_accept), 48'(e));
    @(negedge clk);
    check(flt_valid == 1'b0, "R2 single pulse", 48'(flt_valid), 48'd0);
  endtask

  task automatic set_slot(input int n, input logic [47:0] a, input logic en);
    cfg_write(8'(8'h50 + 8 * n), a[31:0]);
    cfg_write(8'(8'h54 + 8 * n), {en, 15'd0, a[47:32]});
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] d;
    int r, k;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_en[i] = 1'b0; end
    m_prom = 0; m_mall = 0; m_cpass = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_waddr = '0; cfg_wdata = '0; cfg_raddr = '0;
    rx_sof = 1'b0; rx_dst = '0; rx_is_mcast = 0; rx_is_bcast = 0; rx_is_ctrl = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(flt_valid == 1'b0 && flt_accept == 1'b0, "R1 outputs", 48'({flt_valid, flt_accept}), 48'd0);
    read_check(8'h38, "R1 ctrl");
    for (int i = 0; i < 8; i++) begin
      read_check(8'(8'h50 + 8 * i), "R1 slot lo");
      read_check(8'(8'h54 + 8 * i), "R1 slot hi");
    end

    // R3: slot 0 active at reset with address zero
    send(48'd0, 1'b0, 1'b0, 1'b0, "R3 reset slot0");
    send(48'h0000_0000_0001, 1'b1, 1'b0, 1'b0, "R10 no match");

    // R11: byte order
    set_slot(0, 48'h6655_4433_2211, 1'b0);
    send(48'h6655_4433_2211, 1'b1, 1'b0, 1'b0, "R11 byte order");
    send(48'h1122_3344_5566, 1'b0, 1'b0, 1'b0, "R11 swapped drop");
    send(48'h6655_4433_2211, 1'b1, 1'b0, 1'b0, "R3 slot0 no enable");

    // R4: enable bit for slot 3
    set_slot(3, 48'h0A0B_0C0D_0E0F, 1'b0);
    send(48'h0A0B_0C0D_0E0F, 1'b0, 1'b0, 1'b0, "R4 disabled slot");
    set_slot(3, 48'h0A0B_0C0D_0E0F, 1'b1);
    send(48'h0A0B_0C0D_0E0F, 1'b0, 1'b0, 1'b0, "R4 enabled slot");

    // R5: clear by writing zero to high word
    cfg_write(8'h6C, 32'd0);
    send(48'h0000_0C0D_0E0F, 1'b0, 1'b0, 1'b0, "R5 cleared slot");
    send(48'h0A0B_0C0D_0E0F, 1'b0, 1'b0, 1'b0, "R5 old address");

    // R9, R10
    send(48'hFFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, "R9 broadcast");
    send(48'h0100_5E00_0001, 1'b1, 1'b0, 1'b0, "R10 mcast drop");

    // R7
    cfg_write(8'h38, 32'h0001_0000);
    send(48'h0100_5E00_0001, 1'b1, 1'b0, 1'b0, "R7 all multicast");
    send(48'h0200_0000_0077, 1'b0, 1'b0, 1'b0, "R10 unicast drop with R7");

    // R8
    send(48'h0180_C200_0001, 1'b1, 1'b0, 1'b1, "R8 control blocked");
    cfg_write(8'h38, 32'h0000_2000);
    send(48'h0180_C200_0001, 1'b1, 1'b0, 1'b1, "R8 control passed");
    send(48'h6655_4433_2211, 1'b0, 1'b0, 1'b1, "R8 address ignored");

    // R6
    cfg_write(8'h38, 32'h0000_0001);
    send(48'h0200_0000_0099, 1'b0, 1'b0, 1'b0, "R6 promiscuous");
    send(48'h0180_C200_0001, 1'b1, 1'b0, 1'b1, "R6 promiscuous control");

    // R12: stored bits only
    cfg_write(8'h38, 32'hFFFF_FFFF);
    read_check(8'h38, "R12 ctrl mask");
    cfg_write(8'h5C, 32'hFFFF_FFFF);
    read_check(8'h5C, "R12 hi mask");
    cfg_write(8'h58, 32'hDEAD_BEEF);
    read_check(8'h58, "R12 lo full");
    read_check(8'h3C, "R12 hole");
    cfg_write(8'h38, 32'd0);

    // random phase
    for (int f = 0; f < 600; f++) begin
      if (f % 40 == 0) begin
        for (int s = 0; s < 8; s++) begin
          d = {$urandom(), $urandom()};
          set_slot(s, d, 1'($urandom_range(0, 1)));
        end
        r = $urandom_range(0, 9);
        cfg_write(8'h38, {15'd0, 1'(r < 3), 2'b00, 1'(r[0]), 12'd0, 1'(r == 9)});
        for (int s = 0; s < 8; s++) read_check(8'(8'h54 + 8 * s), "R12 random hi");
      end
      r = $urandom_range(0, 9);
      if (r < 5) begin
        k = $urandom_range(0, 7);
        d = {m_hi[k], m_lo[k]};
      end else if (r == 5) begin
        d = '1;
      end else begin
        d = {$urandom(), $urandom()};
      end
      send(d, d[0] | (r == 5), 1'(r == 5), 1'($urandom_range(0, 9) == 0), "R4 R10 random frame");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule